// File: doc/BRIEF.md
# Debug-Mode Peripheral Clock Hold Controller

This block follows whether a small processor core is halted in debug mode. It uses that state to freeze or keep running two groups of peripherals. The first group is clocked from the prescaler: timers, PWM, serial ports and the ADC. The second group is clocked from the slow oscillator: the clock timer, watchdog, stopwatch and slow timer.

Debug mode can start in two ways: a one-cycle strobe from the core when it executes a break instruction, or a falling edge on an external active-low break pin. A one-cycle return strobe ends debug mode. While debug mode is active, the block raises a mask that blocks both maskable interrupts and the NMI.

Software controls each peripheral group through its own run-in-debug bit, which sits behind a simple register port. The block only produces clock-enable outputs; the gating itself is done elsewhere.

Top module: `dbg_clk_hold`

## Requirements
- R1: After a synchronous reset, `dbg_mode_o` and `irq_mask_o` are 0, both enables are 1, and both control bits read as 0.
- R2: A break strobe sampled at a clock edge sets `dbg_mode_o` after that edge.
- R3: The break pin passes through a two-flop synchronizer. A high-to-low change of the pin sampled at edge N sets `dbg_mode_o` after edge N+2. A pin that stays low does not re-enter debug after a return, but a later rise and fall of the pin does.
- R4: A return strobe clears `dbg_mode_o` after the edge, unless a break request comes in the same cycle.
- R5: When a return strobe and a break request arrive in the same cycle, the break request wins and `dbg_mode_o` is 1.
- R6: `irq_mask_o` equals `dbg_mode_o` in every cycle.
- R7: The prescaler run-in-debug bit is bit 1 at address 0x4020. While in debug with this bit at 0, `psc_clk_en_o` is 0; with the bit at 1, it is 1.
- R8: The oscillator run-in-debug bit is bit 0 at address 0x5324. While in debug with this bit at 0, `osc_clk_en_o` is 0; with the bit at 1, it is 1.
- R9: Outside debug mode, both enables are 1 whatever the control bits hold.
- R10: A read returns the stored bit in its own position and zeros in every other bit. Any other address reads as 0, and a write to any other address changes no control bit.
- R11: Writes to the control bits are accepted during debug mode. The enables follow the new value after the write edge, without leaving debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_strobe_i | input | 1 | Break instruction executed (one cycle) |
| ret_strobe_i | input | 1 | Return from debug executed (one cycle) |
| brk_pin_n_i | input | 1 | External break pin, active low, asynchronous |
| bus_wr_i | input | 1 | Register write enable |
| bus_addr_i | input | 16 | Register address, used for both read and write |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data, combinational on address |
| dbg_mode_o | output | 1 | Debug mode active |
| irq_mask_o | output | 1 | Blocks interrupts and NMI |
| psc_clk_en_o | output | 1 | Enable for the prescaler domain |
| osc_clk_en_o | output | 1 | Enable for the slow oscillator domain |

## Verification
The hardest case to reach from the ports is a break pin that stays low across a return. The stimulus pulls the pin low and waits out the synchronizer latency to confirm entry. It then issues a return while the pin stays low and watches several cycles, during which debug mode must not come back. Finally it releases the pin, pulls it low again, and checks that the fresh edge re-enters debug. A second subtle case is a break strobe and a return strobe in the same cycle, which the vector table drives directly.

// File: rtl/dbg_hold_pkg.sv
package dbg_hold_pkg;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned DATA_W = 16;

    localparam logic [ADDR_W-1:0] PSC_CFG_ADDR = 16'h4020;
    localparam logic [ADDR_W-1:0] OSC_CFG_ADDR = 16'h5324;
    localparam int unsigned PSC_RUN_BIT = 1;
    localparam int unsigned OSC_RUN_BIT = 0;

    typedef struct packed {
        logic psc_run;
        logic osc_run;
    } run_cfg_t;

    typedef struct packed {
        logic enter;
        logic leave;
    } dbg_req_t;

    function automatic logic [DATA_W-1:0] place_bit(input logic v, input int unsigned pos);
        logic [DATA_W-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction
endpackage

// File: rtl/dbg_pin_edge.sv
module dbg_pin_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b1;
                else if (i == 0) chain_q[i] <= pin_n_i;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    assign fall_o = last_q & ~chain_q[SYNC_STAGES-1];

    // R3
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/dbg_state_ctl.sv
module dbg_state_ctl
    import dbg_hold_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dbg_req_t req_i,
    output logic     dbg_o
);
    logic dbg_q;

    always_ff @(posedge clk) begin
        if (rst)              dbg_q <= 1'b0;
        else if (req_i.enter) dbg_q <= 1'b1;
        else if (req_i.leave) dbg_q <= 1'b0;
    end

    assign dbg_o = dbg_q;

    // R2
    enter_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req_i.enter |=> dbg_q);
    // R4
    leave_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.leave && !req_i.enter) |=> !dbg_q);
    // R2
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_q) |-> $past(req_i.enter));
endmodule

// File: rtl/dbg_run_regs.sv
module dbg_run_regs
    import dbg_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output run_cfg_t          cfg_o
);
    run_cfg_t cfg_q;
    logic     hit_psc, hit_osc;

    assign hit_psc = (addr_i == PSC_CFG_ADDR);
    assign hit_osc = (addr_i == OSC_CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            if (hit_psc) cfg_q.psc_run <= wdata_i[PSC_RUN_BIT];
            if (hit_osc) cfg_q.osc_run <= wdata_i[OSC_RUN_BIT];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_psc) rdata_o = place_bit(cfg_q.psc_run, PSC_RUN_BIT);
        if (hit_osc) rdata_o = place_bit(cfg_q.osc_run, OSC_RUN_BIT);
    end

    assign cfg_o = cfg_q;

    // R10
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !hit_psc && !hit_osc) |=> $stable(cfg_q));
endmodule

// File: rtl/dbg_clk_hold.sv
module dbg_clk_hold
    import dbg_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_strobe_i,
    input  logic              ret_strobe_i,
    input  logic              brk_pin_n_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              dbg_mode_o,
    output logic              irq_mask_o,
    output logic              psc_clk_en_o,
    output logic              osc_clk_en_o
);
    logic     pin_fall;
    dbg_req_t req;
    run_cfg_t cfg;
    logic     dbg;

    dbg_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (brk_pin_n_i),
        .fall_o  (pin_fall)
    );

    assign req.enter = brk_strobe_i | pin_fall;
    assign req.leave = ret_strobe_i;

    dbg_state_ctl u_state (
        .clk   (clk),
        .rst   (rst),
        .req_i (req),
        .dbg_o (dbg)
    );

    dbg_run_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .cfg_o   (cfg)
    );

    assign dbg_mode_o   = dbg;
    assign irq_mask_o   = dbg;
    assign psc_clk_en_o = ~dbg | cfg.psc_run;
    assign osc_clk_en_o = ~dbg | cfg.osc_run;

    // R9
    psc_stop_only_in_dbg_chk: assert property (@(posedge clk) disable iff (rst)
        !psc_clk_en_o |-> irq_mask_o);
    // R9
    osc_stop_only_in_dbg_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_clk_en_o |-> irq_mask_o);
    // R6
    mask_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq_mask_o == dbg_mode_o);
endmodule

// File: tb/tb_dbg_clk_hold.sv
module tb_dbg_clk_hold;
    logic        clk = 1'b0;
    logic        rst;
    logic        brk_strobe_i, ret_strobe_i, brk_pin_n_i, bus_wr_i;
    logic [15:0] bus_addr_i, bus_wdata_i, bus_rdata_o;
    logic        dbg_mode_o, irq_mask_o, psc_clk_en_o, osc_clk_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_clk_hold dut (.*);

    // brk, ret, wr, addr, wdata, exp dbg, exp psc_en, exp osc_en, exp rdata
    localparam int NV = 10;
    localparam logic [53:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,16'h4020,16'h0000, 1'b0,1'b1,1'b1,16'h0000},
        {1'b0,1'b0,1'b1,16'h4020,16'hFFFF, 1'b0,1'b1,1'b1,16'h0002},
        {1'b1,1'b0,1'b0,16'h5324,16'h0000, 1'b1,1'b1,1'b0,16'h0000},
        {1'b0,1'b0,1'b1,16'h5324,16'h0001, 1'b1,1'b1,1'b1,16'h0001},
        {1'b0,1'b0,1'b1,16'h4020,16'h0000, 1'b1,1'b0,1'b1,16'h0000},
        {1'b0,1'b0,1'b1,16'h4022,16'hFFFF, 1'b1,1'b0,1'b1,16'h0000},
        {1'b0,1'b1,1'b0,16'h5324,16'h0000, 1'b0,1'b1,1'b1,16'h0001},
        {1'b1,1'b1,1'b0,16'h5324,16'h0000, 1'b1,1'b0,1'b1,16'h0001},
        {1'b0,1'b1,1'b0,16'h4020,16'h0000, 1'b0,1'b1,1'b1,16'h0000},
        {1'b0,1'b0,1'b1,16'h5324,16'h0000, 1'b0,1'b1,1'b1,16'h0000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R9";
            1: return "R7/R10";
            2: return "R2/R8";
            3: return "R11/R8";
            4: return "R11/R7";
            5: return "R10";
            6: return "R4/R9";
            7: return "R5";
            8: return "R4";
            default: return "R10/R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        brk_strobe_i = 0; ret_strobe_i = 0; bus_wr_i = 0;
        bus_wdata_i = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; brk_pin_n_i = 1; bus_addr_i = 16'h4020; idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 dbg", {15'b0, dbg_mode_o}, 16'h0);
        chk("R1 mask", {15'b0, irq_mask_o}, 16'h0);
        chk("R1 enables", {14'b0, psc_clk_en_o, osc_clk_en_o}, 16'h3);
        chk("R1 psc read", bus_rdata_o, 16'h0);
        bus_addr_i = 16'h5324; #1;
        chk("R1 osc read", bus_rdata_o, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = VEC[i];
            @(negedge clk);
            brk_strobe_i = v[53]; ret_strobe_i = v[52]; bus_wr_i = v[51];
            bus_addr_i = v[50:35]; bus_wdata_i = v[34:19];
            @(negedge clk);
            idle();
            chk({vec_tag(i), " dbg"}, {15'b0, dbg_mode_o}, {15'b0, v[18]});
            chk({vec_tag(i), " psc_en"}, {15'b0, psc_clk_en_o}, {15'b0, v[17]});
            chk({vec_tag(i), " osc_en"}, {15'b0, osc_clk_en_o}, {15'b0, v[16]});
            chk({vec_tag(i), " rdata"}, bus_rdata_o, v[15:0]);
            chk("R6 mask", {15'b0, irq_mask_o}, {15'b0, dbg_mode_o});
        end

        // R3 pin entry latency: low sampled at edge N, debug after N+2
        @(negedge clk); brk_pin_n_i = 0;
        @(negedge clk); chk("R3 after 1 edge", {15'b0, dbg_mode_o}, 16'h0);
        @(negedge clk); chk("R3 after 2 edges", {15'b0, dbg_mode_o}, 16'h0);
        @(negedge clk); chk("R3 after 3 edges", {15'b0, dbg_mode_o}, 16'h1);
        chk("R6 mask pin", {15'b0, irq_mask_o}, 16'h1);
        // R3 held low: return, no re-entry
        ret_strobe_i = 1;
        @(negedge clk); ret_strobe_i = 0;
        chk("R4 ret with pin low", {15'b0, dbg_mode_o}, 16'h0);
        repeat (5) @(negedge clk);
        chk("R3 held low no reentry", {15'b0, dbg_mode_o}, 16'h0);
        // R3 new fall re-enters
        brk_pin_n_i = 1;
        repeat (4) @(negedge clk);
        chk("R3 high no entry", {15'b0, dbg_mode_o}, 16'h0);
        brk_pin_n_i = 0;
        repeat (3) @(negedge clk);
        chk("R3 second fall", {15'b0, dbg_mode_o}, 16'h1);
        // R8 osc bit 0 in debug stops osc domain
        chk("R8 osc stopped", {15'b0, osc_clk_en_o}, 16'h0);
        // R1 reset clears mode
        rst = 1; @(negedge clk); rst = 0; brk_pin_n_i = 1;
        chk("R1 reset clears", {15'b0, dbg_mode_o}, 16'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule